// File: doc/BRIEF.md
# UART Autobaud Rate Detector

This block lets a UART receiver lock onto an unknown incoming bit rate. Software arms it by writing a one into its enable bit. The detector then waits until the receive line has been seen high. It times the low period of the next start bit in cycles of the 16x oversampling clock. It then writes a new baud rate divider through a one-cycle write strobe. When the block finishes, hits an error, is cleared by software or loses the UART enable, it drops its own enable bit.

The receive line input is taken as already synchronised to `clk_i`. A one-bit write port stands in for the control register. While the detector is armed, received characters are held back from the ready output, so the characters it uses for timing are not handed on as data.

Top module: `uart_autobaud`

## Requirements
- R1: After reset `ab_en_o`, `div_we_o` and `ab_err_o` are 0 and `div_o` is 0.
- R2: Writing 1 (`wr_en_i`=1, `wr_data_i`=1) sets `ab_en_o` at the next edge only if `uart_en_i`=1 and `rx_idle_i`=1. Otherwise the write is ignored.
- R3: Once armed, the block first waits for a sample with `rxd_i`=1. The next sample with `rxd_i`=0 starts the measurement, and N is the number of consecutive low samples.
- R4: When the line is sampled high after N low samples and floor(N/16) >= 2, `div_o` becomes floor(N/16)-1. `div_we_o` pulses for one cycle and `ab_en_o` clears, all at that same edge.
- R5: If floor(N/16) < 2 when the line returns high, `ab_err_o` pulses for one cycle, `ab_en_o` clears, and `div_o` and `div_we_o` are unchanged.
- R6: If the line stays low for 2^CNT_W samples, the counter saturates. `ab_err_o` pulses and `ab_en_o` clears on the edge that sees that sample.
- R7: Writing 0 while `ab_en_o`=1 clears it at the next edge only if `rx_idle_i`=1. Otherwise the write is ignored.
- R8: While `uart_en_i`=0, `ab_en_o` is cleared at the next edge and no divider write or error is produced.
- R9: If an accepted software clear falls in the same cycle as the line returning high, the clear wins. The measurement is dropped with no divider write and no error.
- R10: `rx_valid_o` equals `rx_valid_i` while `ab_en_o`=0 and is 0 while `ab_en_o`=1.
- R11: `div_o` changes only on a cycle where `div_we_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock (16x bit rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uart_en_i | input | 1 | UART enable; low forces the detector off |
| rx_idle_i | input | 1 | Receiver idle indication |
| rxd_i | input | 1 | Synchronised receive line |
| wr_en_i | input | 1 | Write strobe for the enable bit |
| wr_data_i | input | 1 | Value written to the enable bit |
| rx_valid_i | input | 1 | Character-ready from the receiver |
| ab_en_o | output | 1 | Enable bit readback |
| div_o | output | CNT_W-4 | Baud rate divider value |
| div_we_o | output | 1 | One-cycle divider write strobe |
| ab_err_o | output | 1 | One-cycle autobaud error pulse |
| rx_valid_o | output | 1 | Character-ready passed on when not armed |

## Verification
The two functions that can land in the same cycle are the software clear and the end of the measurement, when the line returns high. The bench provokes this by driving a clear with the receiver idle in exactly the cycle that ends a valid-length start bit. It expects the enable bit to drop with no divider strobe and the previous divider kept. The bench also has the UART enable fall in the middle of a measurement. A reference model with integer state predicts every output on every clock.

// File: rtl/uart_autobaud_pkg.sv
package uart_autobaud_pkg;
  localparam int OSR_LOG2 = 4;  // 16x oversampling
  localparam int MIN_Q    = 2;  // smallest quotient giving a non-zero divider

  typedef enum logic [1:0] {
    ST_OFF,
    ST_ARM,
    ST_READY,
    ST_MEAS
  } ab_state_e;
endpackage

// File: rtl/ab_counter.sv
module ab_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  logic [CNT_W-1:0] cnt_q;

  assign sat_o = &cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CNT_W'(1);
    else if (inc_i && !sat_o)  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/ab_div_calc.sv
module ab_div_calc
  import uart_autobaud_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int DIV_W = CNT_W - OSR_LOG2
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [DIV_W-1:0] div_o,
  output logic             bad_o
);
  logic [CNT_W-1:0] quot;

  always_comb begin
    quot  = cnt_i >> OSR_LOG2;
    bad_o = quot < CNT_W'(MIN_Q);
    div_o = DIV_W'(quot - CNT_W'(1));
  end
endmodule

// File: rtl/ab_ctrl.sv
module ab_ctrl
  import uart_autobaud_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uart_en_i,
  input  logic             rx_idle_i,
  input  logic             rxd_i,
  input  logic             wr_en_i,
  input  logic             wr_data_i,
  input  logic             sat_i,
  input  logic             bad_i,
  input  logic [DIV_W-1:0] div_calc_i,
  output logic             ab_en_o,
  output logic             start_o,
  output logic             inc_o,
  output logic [DIV_W-1:0] div_o,
  output logic             div_we_o,
  output logic             err_o
);
  ab_state_e  state_q;
  logic       en_q, we_q, err_q;
  logic [DIV_W-1:0] div_q;
  logic       sw_clr, sw_set;

  assign sw_clr  = wr_en_i && !wr_data_i && rx_idle_i && en_q;
  assign sw_set  = wr_en_i &&  wr_data_i && rx_idle_i && uart_en_i && !en_q;
  assign start_o = uart_en_i && en_q && !sw_clr && (state_q == ST_READY) && !rxd_i;
  assign inc_o   = (state_q == ST_MEAS) && !rxd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      en_q    <= 1'b0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      div_q   <= '0;
    end else begin
      we_q  <= 1'b0;
      err_q <= 1'b0;
      if (!uart_en_i || sw_clr) begin
        en_q    <= 1'b0;
        state_q <= ST_OFF;
      end else if (sw_set) begin
        en_q    <= 1'b1;
        state_q <= ST_ARM;
      end else if (en_q) begin
        unique case (state_q)
          ST_ARM:   if (rxd_i)  state_q <= ST_READY;
          ST_READY: if (!rxd_i) state_q <= ST_MEAS;
          ST_MEAS: begin
            if (rxd_i) begin
              if (bad_i) err_q <= 1'b1;
              else begin
                div_q <= div_calc_i;
                we_q  <= 1'b1;
              end
              en_q    <= 1'b0;
              state_q <= ST_OFF;
            end else if (sat_i) begin
              err_q   <= 1'b1;
              en_q    <= 1'b0;
              state_q <= ST_OFF;
            end
          end
          default: state_q <= ST_OFF;
        endcase
      end
    end
  end

  assign ab_en_o  = en_q;
  assign div_o    = div_q;
  assign div_we_o = we_q;
  assign err_o    = err_q;
endmodule

// File: rtl/uart_autobaud.sv
module uart_autobaud
  import uart_autobaud_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int DIV_W = CNT_W - OSR_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uart_en_i,
  input  logic             rx_idle_i,
  input  logic             rxd_i,
  input  logic             wr_en_i,
  input  logic             wr_data_i,
  input  logic             rx_valid_i,
  output logic             ab_en_o,
  output logic [DIV_W-1:0] div_o,
  output logic             div_we_o,
  output logic             ab_err_o,
  output logic             rx_valid_o
);
  logic [CNT_W-1:0] cnt;
  logic             sat, bad, start, inc;
  logic [DIV_W-1:0] div_calc;

  ab_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .inc_i  (inc),
    .cnt_o  (cnt),
    .sat_o  (sat)
  );

  ab_div_calc #(.CNT_W(CNT_W)) u_calc (
    .cnt_i(cnt),
    .div_o(div_calc),
    .bad_o(bad)
  );

  ab_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .uart_en_i (uart_en_i),
    .rx_idle_i (rx_idle_i),
    .rxd_i     (rxd_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .sat_i     (sat),
    .bad_i     (bad),
    .div_calc_i(div_calc),
    .ab_en_o   (ab_en_o),
    .start_o   (start),
    .inc_o     (inc),
    .div_o     (div_o),
    .div_we_o  (div_we_o),
    .err_o     (ab_err_o)
  );

  // characters used for timing are not passed on
  assign rx_valid_o = rx_valid_i && !ab_en_o;
endmodule

// File: rtl/ab_chk.sv
module ab_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             uart_en_i,
  input logic             rx_idle_i,
  input logic             wr_en_i,
  input logic             wr_data_i,
  input logic             ab_en_o,
  input logic [DIV_W-1:0] div_o,
  input logic             div_we_o,
  input logic             ab_err_o
);
  p_set_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_en_o && !(wr_en_i && wr_data_i && uart_en_i && rx_idle_i)) |=> !ab_en_o);

  p_we_clears_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_o |-> !ab_en_o);

  p_div_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_o |-> (div_o != '0));

  p_err_clears_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_err_o |-> (!ab_en_o && !div_we_o));

  p_uart_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uart_en_i |=> (!ab_en_o && !div_we_o && !ab_err_o));

  p_div_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_we_o |=> (div_we_o || $stable(div_o)));
endmodule

bind uart_autobaud ab_chk #(.DIV_W(DIV_W)) u_ab_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .uart_en_i(uart_en_i),
  .rx_idle_i(rx_idle_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .ab_en_o  (ab_en_o),
  .div_o    (div_o),
  .div_we_o (div_we_o),
  .ab_err_o (ab_err_o)
);

// File: tb/uart_autobaud_tb_top.sv
`timescale 1ns/1ps
module uart_autobaud_tb_top;
  localparam int CNT_W = 10;
  localparam int DIV_W = CNT_W - 4;
  localparam int LIMIT = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic uart_en = 1'b1, rx_idle = 1'b1, rxd = 1'b1;
  logic wr_en = 1'b0, wr_data = 1'b0, rx_valid = 1'b0;
  logic ab_en, div_we, ab_err, rxv_out;
  logic [DIV_W-1:0] div;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_autobaud #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .uart_en_i(uart_en), .rx_idle_i(rx_idle),
    .rxd_i(rxd), .wr_en_i(wr_en), .wr_data_i(wr_data), .rx_valid_i(rx_valid),
    .ab_en_o(ab_en), .div_o(div), .div_we_o(div_we), .ab_err_o(ab_err),
    .rx_valid_o(rxv_out)
  );

  // reference model: phase 0 off, 1 wait high, 2 wait fall, 3 counting
  int m_en, m_ph, m_low, m_div, m_we, m_err;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ph = 0; m_low = 0; m_div = 0; m_we = 0; m_err = 0;
    end else begin
      m_we = 0; m_err = 0;
      if (!uart_en) begin m_en = 0; m_ph = 0; end
      else if (m_en == 1 && wr_en && !wr_data && rx_idle) begin m_en = 0; m_ph = 0; end
      else if (m_en == 0 && wr_en && wr_data && rx_idle) begin m_en = 1; m_ph = 1; end
      else if (m_en == 1) begin
        if (m_ph == 1) begin
          if (rxd) m_ph = 2;
        end else if (m_ph == 2) begin
          if (!rxd) begin m_ph = 3; m_low = 1; end
        end else if (rxd) begin
          if (m_low / 16 >= 2) begin m_div = m_low / 16 - 1; m_we = 1; end
          else m_err = 1;
          m_en = 0; m_ph = 0;
        end else if (m_low == LIMIT) begin
          m_err = 1; m_en = 0; m_ph = 0;
        end else m_low++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 ab_en", int'(ab_en), m_en);
    chk("R4 div", int'(div), m_div);
    chk("R4 div_we", int'(div_we), m_we);
    chk("R5 ab_err", int'(ab_err), m_err);
    chk("R10 rx_valid", int'(rxv_out), (rx_valid && m_en == 0) ? 1 : 0);
  endtask

  task automatic step(input logic l, input logic we = 0, input logic wd = 0);
    rxd = l; wr_en = we; wr_data = wd;
    @(posedge clk);
    @(negedge clk);
    compare_all();
    wr_en = 0;
  endtask

  task automatic arm();
    step(1, 1, 1);
    step(1);
  endtask

  task automatic lows(input int n);
    for (int i = 0; i < n; i++) step(0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!done) $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ab_en", int'(ab_en), 0);
    chk("R1 div", int'(div), 0);
    chk("R1 div_we", int'(div_we), 0);
    chk("R1 ab_err", int'(ab_err), 0);

    // R2: set ignored without uart enable / receiver idle
    uart_en = 0; step(1, 1, 1); chk("R2 set uart off", int'(ab_en), 0);
    uart_en = 1; rx_idle = 0; step(1, 1, 1); chk("R2 set busy", int'(ab_en), 0);
    rx_idle = 1;

    // R4: 160 low samples -> 9
    arm(); lows(160); step(1);
    chk("R4 div 160", int'(div), 9); chk("R4 we", int'(div_we), 1);
    chk("R4 en self-clear", int'(ab_en), 0);
    step(1); chk("R4 we pulse", int'(div_we), 0);

    // R4: boundary 47 -> 1
    arm(); lows(47); step(1); chk("R4 div 47", int'(div), 1);

    // R5: 31 -> error, divider kept
    arm(); lows(31); step(1);
    chk("R5 err", int'(ab_err), 1); chk("R5 div kept", int'(div), 1);
    chk("R5 en self-clear", int'(ab_en), 0);

    // R3: armed while line low; waits for high before timing
    rxd = 0; step(0, 1, 1); lows(40); step(1); step(1);
    chk("R3 waiting", int'(ab_en), 1);
    lows(64); step(1); chk("R3 div 64", int'(div), 3);

    // R10: character gating
    rx_valid = 1; arm(); chk("R10 gated", int'(rxv_out), 0);
    // R7: clear while receiver busy ignored
    lows(10); rx_idle = 0; step(0, 1, 0); chk("R7 busy clear", int'(ab_en), 1);
    rx_idle = 1; lows(30); step(1); chk("R7 div 41", int'(div), 1);
    chk("R10 passed", int'(rxv_out), 1);
    rx_valid = 0;

    // R7: clear while idle accepted
    arm(); step(1, 1, 0); chk("R7 idle clear", int'(ab_en), 0);

    // R9: clear collides with line returning high
    arm(); lows(100); step(1, 1, 0);
    chk("R9 no we", int'(div_we), 0); chk("R9 div kept", int'(div), 1);
    chk("R9 en", int'(ab_en), 0);

    // R8: uart enable drop mid-measurement
    arm(); lows(80); uart_en = 0; step(0); uart_en = 1;
    chk("R8 en", int'(ab_en), 0);
    step(1); chk("R8 no we", int'(div_we), 0);

    // R6: saturation
    arm(); lows(LIMIT); chk("R6 not yet", int'(ab_err), 0);
    step(0); chk("R6 sat err", int'(ab_err), 1);
    step(1); chk("R6 no we", int'(div_we), 0);

    // R11: divider steady over idle cycles
    repeat (5) step(1);
    chk("R11 div steady", int'(div), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule